// File: doc/BRIEF.md
# Flash Identification and Query Responder

This block produces the read data that a bank of parallel flash devices returns while in identifier mode or in query mode. The bank is built from identical devices of one data width that sit side by side on a wider bus. Each device may be driven narrower than its widest native width. The block turns the incoming bus byte offset into a per-device table index. It looks up what a single device would answer, and copies that answer into every device lane of the bank. The sizes of the bank and the devices are fixed by parameters. All widths are powers of two, given in bytes.

An access may be wider than the bank. In that case the block forms one bank-wide answer for each bank-width step of the address and packs them together. The lowest address lands in the lowest bits. The answer is computed combinationally from the offset and the mode select, then captured in one output register when a read is strobed. Command decoding and the storage array sit elsewhere in the flash model; this block only supplies the data for the two information modes.

Top module: `flash_qry_resp`

## Requirements
- R1: The table index for each step is (byte offset + step × BANK_W) shifted right by log2(BANK_W) + log2(MAX_DEV_W) − log2(DEV_W). The offset bits below that shift do not change the result.
- R2: In query mode, an index equal to or above TBL_DEPTH returns zero. All index bits take part in this test, so index 0x110 reads zero and does not alias to 0x10.
- R3: When DEV_W is 1 and MAX_DEV_W is larger (narrow mode, allowed for BANK_W up to 4), the query byte appears in every byte of the bank answer and is never zero-padded.
- R4: When DEV_W equals MAX_DEV_W, the query byte is zero-extended to DEV_W bytes, and that chunk is copied into each DEV_W-byte lane of the bank.
- R5: For any other combination with DEV_W below MAX_DEV_W (DEV_W above 1, or BANK_W above 4), every query read returns zero. Identifier reads still work normally.
- R6: In identifier mode only index bits [7:0] count. Value 0 gives MFR_CODE and value 1 gives DEV_CODE, each truncated or zero-extended to DEV_W bytes and copied into every lane. Any other value gives zero.
- R7: With ACC_BYTES = k × BANK_W, step s uses address offset + s × BANK_W, and its answer occupies rd_data bits [s×BANK_W×8 +: BANK_W×8].
- R8: A read strobed with rd_en high at a clock edge shows on rd_data, with rd_valid high, right after that edge. With rd_en low, rd_valid goes low and rd_data keeps its previous value.
- R9: While rst_n is low at a clock edge, rd_data clears to zero and rd_valid clears to low.
- R10: The query table holds 0x51, 0x52, 0x59 ('Q','R','Y') at indices 0x10, 0x11, 0x12. It holds 0x01 at index 0x13 and SIZE_LOG2 at index 0x27. Entries left undefined read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read strobe; captures the answer at this edge |
| qry_sel | input | 1 | 1 = query mode, 0 = identifier mode |
| byte_off | input | ADDR_W | Bus byte offset of the access |
| rd_data | output | ACC_BYTES×8 | Registered answer |
| rd_valid | output | 1 | High for the cycle after a strobed read |

## Verification
The bench drives three copies of the block from shared inputs, each with a different bank shape.

The first copy uses a 2-byte bank of byte-wide devices whose widest mode is 16-bit, read through a 4-byte access. This reaches narrow-mode repetition, the two-step packing with distinct indices per step, and the two-bit address shift.

The second copy uses a 4-byte bank of native 16-bit devices. It exposes zero-extension inside each lane and 16-bit identifier codes.

The third copy uses an 8-byte bank of byte-wide devices whose widest mode is 16-bit. This is the unsupported narrow case, so query reads must come back zero while identifier reads still replicate across eight lanes.

// File: rtl/qry_pkg.sv
// Package: shared types and the query table contents for the
// flash identification/query responder.
// Assumes table indices fit in 32 bits.
package qry_pkg;

    // How a device answers query reads, chosen from the width parameters.
    typedef enum logic [1:0] {
        QW_NATIVE = 2'd0,   // device runs at its widest width
        QW_NARROW = 2'd1,   // byte-wide use of a wider part
        QW_UNSUP  = 2'd2    // mismatch that is not supported
    } qry_width_e;

    // Picks the query variant from bank, device and maximum device width.
    function automatic qry_width_e pick_variant(int unsigned bank_w,
                                                int unsigned dev_w,
                                                int unsigned max_w);
        if (dev_w == max_w)
            return QW_NATIVE;
        else if (dev_w == 1 && bank_w <= 4)
            return QW_NARROW;
        else
            return QW_UNSUP;
    endfunction

    // One byte of the per-device query table; undefined entries are zero.
    function automatic logic [7:0] qry_entry(logic [31:0] idx,
                                             logic [7:0]  size_log2,
                                             logic [7:0]  wbuf_log2);
        case (idx)
            32'h10:  return 8'h51;      // 'Q'
            32'h11:  return 8'h52;      // 'R'
            32'h12:  return 8'h59;      // 'Y'
            32'h13:  return 8'h01;      // command set code
            32'h15:  return 8'h31;      // extended table pointer
            32'h1B:  return 8'h45;      // supply min
            32'h1C:  return 8'h55;      // supply max
            32'h27:  return size_log2;  // device size as a power of two
            32'h28:  return 8'h02;      // interface code
            32'h2A:  return wbuf_log2;  // write buffer size as a power of two
            32'h2C:  return 8'h01;      // one uniform erase region
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/qry_rom.sv
// Module: qry_rom
// Holds the per-device query table as a small constant ROM and returns
// one byte for a full-width index. An index at or beyond TBL_DEPTH reads
// zero. All index bits are compared, so high indices never alias.
// Assumes TBL_DEPTH >= 1.
module qry_rom
    import qry_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned TBL_DEPTH = 82,
    parameter logic [7:0]  SIZE_LOG2 = 8'h17,
    parameter logic [7:0]  WBUF_LOG2 = 8'h0B
) (
    input  logic [ADDR_W-1:0] idx,
    output logic [7:0]        q_byte
);

    logic [31:0] idx_w;

    // Widen the index so the range check uses every bit.
    always_comb idx_w = 32'(idx);

    // Table lookup with out-of-range suppression.
    always_comb begin
        if (idx_w < TBL_DEPTH)
            q_byte = qry_entry(idx_w, SIZE_LOG2, WBUF_LOG2);
        else
            q_byte = 8'h00;
    end

endmodule

// File: rtl/qry_lane_fill.sv
// Module: qry_lane_fill
// Copies one device-wide chunk into every device lane of the bank.
// Assumes BANK_W is a multiple of DEV_W.
module qry_lane_fill #(
    parameter int unsigned BANK_W = 2,
    parameter int unsigned DEV_W  = 1
) (
    input  logic [DEV_W*8-1:0]  chunk,
    output logic [BANK_W*8-1:0] bank_word
);

    localparam int unsigned LANES  = BANK_W / DEV_W;
    localparam int unsigned LANE_B = DEV_W * 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Each lane carries the same device answer.
        assign bank_word[l*LANE_B +: LANE_B] = chunk;
    end

endmodule

// File: rtl/qry_step.sv
// Module: qry_step
// Builds one bank-wide answer for one address step. It scales the byte
// address into a table index, forms one device's answer for the selected
// mode, and spreads it over the bank.
// Assumes power-of-two widths, ADDR_W >= 8 and DEV_W <= 4.
module qry_step
    import qry_pkg::*;
#(
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned DEV_W     = 1,
    parameter int unsigned MAX_DEV_W = 2,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned TBL_DEPTH = 82,
    parameter logic [15:0] MFR_CODE  = 16'h0089,
    parameter logic [15:0] DEV_CODE  = 16'h0018,
    parameter logic [7:0]  SIZE_LOG2 = 8'h17,
    parameter logic [7:0]  WBUF_LOG2 = 8'h0B
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                qry_sel,
    input  logic [ADDR_W-1:0]   addr,
    output logic [BANK_W*8-1:0] bank_word
);

    localparam int unsigned SHIFT  = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
    localparam int unsigned LANE_B = DEV_W * 8;
    localparam qry_width_e  VARIANT = pick_variant(BANK_W, DEV_W, MAX_DEV_W);
    localparam logic [LANE_B-1:0] MFR_T = LANE_B'({16'h0000, MFR_CODE});
    localparam logic [LANE_B-1:0] DEV_T = LANE_B'({16'h0000, DEV_CODE});

    logic [ADDR_W-1:0] idx;
    logic [LANE_B-1:0] id_chunk;
    logic [LANE_B-1:0] q_chunk;
    logic [LANE_B-1:0] chunk;

    // Scale the byte address into a device table index.
    always_comb idx = addr >> SHIFT;

    // Identifier answer: low index byte selects manufacturer or device code.
    always_comb begin
        case (idx[7:0])
            8'd0:    id_chunk = MFR_T;
            8'd1:    id_chunk = DEV_T;
            default: id_chunk = '0;
        endcase
    end

    if (VARIANT == QW_UNSUP) begin : g_unsup
        // Unsupported width mix: query data is forced to zero.
        assign q_chunk = '0;
    end else begin : g_rom
        logic [7:0] q_byte;

        qry_rom #(
            .ADDR_W   (ADDR_W),
            .TBL_DEPTH(TBL_DEPTH),
            .SIZE_LOG2(SIZE_LOG2),
            .WBUF_LOG2(WBUF_LOG2)
        ) i_rom (
            .idx   (idx),
            .q_byte(q_byte)
        );

        if (VARIANT == QW_NARROW) begin : g_narrow
            // Byte-wide use: the byte is repeated over the part's full width,
            // of which the single byte lane is what reaches the bus.
            assign q_chunk = q_byte;
        end else begin : g_native
            // Native width: byte sits in the low end of the device lane.
            assign q_chunk = LANE_B'(q_byte);
        end
    end

    // Pick the device answer for the current mode.
    always_comb chunk = qry_sel ? q_chunk : id_chunk;

    qry_lane_fill #(
        .BANK_W(BANK_W),
        .DEV_W (DEV_W)
    ) i_fill (
        .chunk    (chunk),
        .bank_word(bank_word)
    );

    // Returns 1 when every device lane of a bank word matches lane 0.
    function automatic logic lanes_match(logic [BANK_W*8-1:0] w);
        for (int l = 1; l < BANK_W / DEV_W; l++)
            if (w[l*LANE_B +: LANE_B] != w[LANE_B-1:0])
                return 1'b0;
        return 1'b1;
    endfunction

    // R3 R4 R6
    lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lanes_match(bank_word));

    // R6
    id_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!qry_sel && idx[7:0] > 8'd1) |-> (bank_word == '0));

    // R2
    range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_sel && 32'(idx) >= TBL_DEPTH) |-> (bank_word == '0));

    if (VARIANT == QW_UNSUP) begin : g_unsup_chk
        // R5
        unsup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            qry_sel |-> (bank_word == '0));
    end

endmodule

// File: rtl/flash_qry_resp.sv
// Module: flash_qry_resp (top)
// Read-data generator for the identifier and query modes of a flash
// bank. Splits an access into bank-width steps, answers each step, packs
// the answers lowest address first, and registers the result once.
// Assumes ACC_BYTES is a multiple of BANK_W, BANK_W a multiple of DEV_W,
// and MAX_DEV_W >= DEV_W, all powers of two.
module flash_qry_resp #(
    parameter int unsigned BANK_W    = 2,
    parameter int unsigned DEV_W     = 1,
    parameter int unsigned MAX_DEV_W = 2,
    parameter int unsigned ACC_BYTES = 4,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned TBL_DEPTH = 82,
    parameter logic [15:0] MFR_CODE  = 16'h0089,
    parameter logic [15:0] DEV_CODE  = 16'h0018,
    parameter logic [7:0]  SIZE_LOG2 = 8'h17,
    parameter logic [7:0]  WBUF_LOG2 = 8'h0B
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic                   qry_sel,
    input  logic [ADDR_W-1:0]      byte_off,
    output logic [ACC_BYTES*8-1:0] rd_data,
    output logic                   rd_valid
);

    localparam int unsigned STEPS     = ACC_BYTES / BANK_W;
    localparam int unsigned BANK_BITS = BANK_W * 8;

    logic [ACC_BYTES*8-1:0] resp;

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        logic [ADDR_W-1:0]    step_addr;
        logic [BANK_BITS-1:0] step_word;

        // Address of this step: one bank width further per step.
        assign step_addr = byte_off + ADDR_W'(s * BANK_W);

        qry_step #(
            .BANK_W   (BANK_W),
            .DEV_W    (DEV_W),
            .MAX_DEV_W(MAX_DEV_W),
            .ADDR_W   (ADDR_W),
            .TBL_DEPTH(TBL_DEPTH),
            .MFR_CODE (MFR_CODE),
            .DEV_CODE (DEV_CODE),
            .SIZE_LOG2(SIZE_LOG2),
            .WBUF_LOG2(WBUF_LOG2)
        ) i_step (
            .clk      (clk),
            .rst_n    (rst_n),
            .qry_sel  (qry_sel),
            .addr     (step_addr),
            .bank_word(step_word)
        );

        assign resp[s*BANK_BITS +: BANK_BITS] = step_word;
    end

    // Output register: capture on a strobed read, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= resp;
        end
    end

    // R8
    valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/test_flash_qry_resp.sv
// Directed bench: three bank shapes share one set of inputs.
module test_flash_qry_resp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        qry_sel = 1'b0;
    logic [15:0] byte_off = '0;

    logic [31:0] d_nar;
    logic [31:0] d_nat;
    logic [63:0] d_uns;
    logic        v_nar, v_nat, v_uns;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    // Narrow mode: 2-byte bank, byte devices of 16-bit maximum, 4-byte access.
    flash_qry_resp i_flash_qry_resp (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .qry_sel(qry_sel),
        .byte_off(byte_off), .rd_data(d_nar), .rd_valid(v_nar));

    // Native 16-bit devices in a 4-byte bank.
    flash_qry_resp #(.BANK_W(4), .DEV_W(2), .MAX_DEV_W(2), .ACC_BYTES(4))
    i_flash_qry_resp_nat (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .qry_sel(qry_sel),
        .byte_off(byte_off), .rd_data(d_nat), .rd_valid(v_nat));

    // Unsupported narrow mix: 8-byte bank of byte-used 16-bit parts.
    flash_qry_resp #(.BANK_W(8), .DEV_W(1), .MAX_DEV_W(2), .ACC_BYTES(8))
    i_flash_qry_resp_uns (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .qry_sel(qry_sel),
        .byte_off(byte_off), .rd_data(d_uns), .rd_valid(v_uns));

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 got=%0d exp<=20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One strobed read; returns at the next falling edge with outputs updated.
    task automatic rd(logic q, logic [15:0] off);
        @(negedge clk);
        rd_en = 1'b1;
        qry_sel = q;
        byte_off = off;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 data", {d_uns, d_nar}, 64'h0);
        chk("R9 valid", {61'h0, v_nar, v_nat, v_uns}, 64'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_table;
        rd(1'b1, 16'h0042);
        chk("R10 R7 Q/R steps", 64'(d_nar), 64'h5252_5151);
        rd(1'b1, 16'h0048);
        chk("R10 Y", 64'(d_nar), 64'h5959_5959);
        rd(1'b1, 16'h004C);
        chk("R10 cmd set", 64'(d_nar), 64'h0101_0101);
        rd(1'b1, 16'h009C);
        chk("R10 size", 64'(d_nar), 64'h1717_1717);
    endtask

    task automatic t_shift;
        rd(1'b1, 16'h0043);
        chk("R1 low bits dropped", 64'(d_nar), 64'h5252_5151);
        rd(1'b1, 16'h0044);
        chk("R1 index 0x11", 64'(d_nar), 64'h5252_5252);
        chk("R3 narrow repeat", 64'(d_nar[15:8]), 64'h52);
    endtask

    task automatic t_range;
        rd(1'b1, 16'h0440);
        chk("R2 no alias 0x110", 64'(d_nar), 64'h0);
        rd(1'b1, 16'h0148);
        chk("R2 index 0x52", 64'(d_nar), 64'h0);
    endtask

    task automatic t_native;
        rd(1'b1, 16'h0040);
        chk("R4 native Q", 64'(d_nat), 64'h0051_0051);
        rd(1'b0, 16'h0004);
        chk("R4 R6 native dev code", 64'(d_nat), 64'h0018_0018);
    endtask

    task automatic t_unsup;
        rd(1'b1, 16'h0100);
        chk("R5 query zero", d_uns, 64'h0);
        rd(1'b0, 16'h0010);
        chk("R5 id still works", d_uns, 64'h1818_1818_1818_1818);
        rd(1'b0, 16'h0000);
        chk("R5 R6 mfr x8", d_uns, 64'h8989_8989_8989_8989);
    endtask

    task automatic t_ident;
        rd(1'b0, 16'h0000);
        chk("R6 mfr", 64'(d_nar), 64'h8989_8989);
        rd(1'b0, 16'h0002);
        chk("R6 R7 mfr+dev", 64'(d_nar), 64'h1818_8989);
        rd(1'b0, 16'h0008);
        chk("R6 other zero", 64'(d_nar), 64'h0);
        rd(1'b0, 16'h0400);
        chk("R6 low byte only", 64'(d_nar), 64'h8989_8989);
        rd(1'b0, 16'h0000);
        chk("R6 native mfr", 64'(d_nat), 64'h0089_0089);
    endtask

    task automatic t_timing;
        rd(1'b1, 16'h0040);
        chk("R8 valid", 64'(v_nar), 64'h1);
        chk("R8 data", 64'(d_nar), 64'h5151_5151);
        @(negedge clk);
        qry_sel = 1'b0;
        byte_off = 16'h0002;
        @(negedge clk);
        chk("R8 valid low", 64'(v_nar), 64'h0);
        chk("R8 hold", 64'(d_nar), 64'h5151_5151);
    endtask

    initial begin
        t_reset();
        t_table();
        t_shift();
        t_range();
        t_native();
        t_unsup();
        t_ident();
        t_timing();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule